// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block turns one PCIe configuration access into the four dwords that a root port sends downstream: three header dwords followed by one data dword. A requester presents the target bus, device, function, register offset, access size, write data and direction, together with the local root bus number and the secondary bus number. The block works out the byte enables, aligns the offset to a dword, picks the Type 0 or Type 1 format, fills in the requester ID and tag, and places write data in its byte lane.

Both edges use a valid/ready handshake. The request is captured in full when it is accepted. The packet then leaves as a four-beat stream with start and end markers. No second request is taken until the last beat has been accepted downstream.

Top module: `cfg_tlp_gen`

## Requirements
- R1: After reset, `tx_valid` is low and `req_ready` is high.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the last beat has been taken. It is high again in the cycle after the last beat is taken.
- R3: The packet is four beats, in this order: header dword 0 with `tx_sop` high, header dword 1, header dword 2, then the data dword with `tx_eop` high. The two middle beats carry neither marker. The first beat is valid in the cycle after acceptance.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sop` and `tx_eop` hold their values.
- R5: The format is Type 1 when `req_bus` is strictly greater than `sec_bus`, and Type 0 otherwise. The format/type code is 0x04 for a Type 0 read, 0x44 for a Type 0 write, 0x05 for a Type 1 read and 0x45 for a Type 1 write.
- R6: Header dword 0 is the format/type code in bits [31:24], with bits [23:0] equal to 1 (length of one dword).
- R7: Header dword 1 is `{root_bus, 8'h00, tag, byte_enables}`. The tag is 0x1D for reads and 0x10 for writes.
- R8: The `req_size` encoding is 0 = byte, 1 = halfword, 2 or 3 = dword. Byte enables are 8'h01 shifted left by `req_offset[1:0]` for a byte and 8'h03 shifted left by `req_offset[1:0]` for a halfword, both kept to 8 bits. For a dword they are 8'h0F.
- R9: Header dword 2 has `req_bus` in [31:24], `req_dev` in [23:19] and `req_func` in [18:16]. Its bits [15:0] hold the offset with bits [1:0] cleared; bits [15:12] are zero.
- R10: For a read (`req_write` = 0) the data dword is zero. For a write, a dword access sends `req_wdata` unchanged. A byte or halfword access sends the low 8 or 16 bits of `req_wdata` shifted left by 8 × `req_offset[1:0]`, kept to 32 bits.
- R11: Changes on the request inputs after acceptance have no effect on the packet in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_offset | input | OFS_W | Register byte offset |
| req_wdata | input | 32 | Write value, right-justified |
| root_bus | input | 8 | Local root bus number (requester ID) |
| sec_bus | input | 8 | Secondary bus number |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Downstream takes beat |
| tx_data | output | 32 | Beat payload |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |

## Verification
The bench sweeps direction, every size code and every low offset pair, with the target bus set below, equal to, just above and far above the secondary bus. The equal case catches a greater-or-equal comparison, which would send a Type 1 code to the bus directly below the port. Halfword and byte writes at offset 3 catch byte enables or data that are not kept to their field width, or that are placed in the wrong lane. Random-looking stalls between beats, with new request values driven in the meantime, catch beats that advance or change under back-pressure. They also catch a packet that picks up the later request fields, or a second request that slips in before the end marker.

// File: rtl/cfg_tlp_gen.sv
module cfg_tlp_gen #(
  parameter int          OFS_W  = 12,
  parameter logic [7:0]  RD_TAG = 8'h1D,
  parameter logic [7:0]  WR_TAG = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [7:0]       req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_func,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [31:0]      req_wdata,
  input  logic [7:0]       root_bus,
  input  logic [7:0]       sec_bus,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [31:0]      tx_data,
  output logic             tx_sop,
  output logic             tx_eop
);
  localparam int PAD_W = 16 - OFS_W;

  logic              busy;
  logic [1:0]        beat;
  logic [3:0][31:0]  pkt_q;
  logic [3:0][31:0]  pkt_d;
  logic [7:0]        code, be;
  logic [31:0]       lane_data;
  logic [4:0]        sh;
  logic              far_bus;

  assign far_bus = req_bus > sec_bus;
  assign sh      = {req_offset[1:0], 3'b000};
  assign code    = {1'b0, req_write, 5'b00010, far_bus};

  always_comb begin
    case (req_size)
      2'd0:    be = 8'h01 << req_offset[1:0];
      2'd1:    be = 8'h03 << req_offset[1:0];
      default: be = 8'h0F;
    endcase
  end

  always_comb begin
    case (req_size)
      2'd0:    lane_data = {24'h0, req_wdata[7:0]} << sh;
      2'd1:    lane_data = {16'h0, req_wdata[15:0]} << sh;
      default: lane_data = req_wdata;
    endcase
  end

  assign pkt_d[0] = {code, 24'h000001};
  assign pkt_d[1] = {root_bus, 8'h00, req_write ? WR_TAG : RD_TAG, be};
  assign pkt_d[2] = {req_bus, req_dev, req_func, {PAD_W{1'b0}},
                     req_offset[OFS_W-1:2], 2'b00};
  assign pkt_d[3] = req_write ? lane_data : 32'h0;

  assign req_ready = !busy;
  assign tx_valid  = busy;
  assign tx_data   = pkt_q[beat];
  assign tx_sop    = busy && beat == 2'd0;
  assign tx_eop    = busy && beat == 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      beat  <= 2'd0;
      pkt_q <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy  <= 1'b1;
        beat  <= 2'd0;
        pkt_q <= pkt_d;
      end
    end else if (tx_ready) begin
      beat <= beat + 2'd1;
      if (beat == 2'd3) busy <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !tx_valid && req_ready); // R1
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> tx_valid && tx_sop && !req_ready); // R2
  AST_EOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eop |=> req_ready && !tx_valid); // R2
  AST_SOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !tx_eop |=> tx_valid && !tx_sop); // R3
  AST_MARKERS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_sop, tx_eop})); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)); // R4
endmodule

// File: tb/test_cfg_tlp_gen.sv
module test_cfg_tlp_gen;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, tx_valid, tx_ready, tx_sop, tx_eop;
  logic [1:0]  req_size;
  logic [7:0]  req_bus, root_bus, sec_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic [11:0] req_offset;
  logic [31:0] req_wdata, tx_data;

  cfg_tlp_gen i_cfg_tlp_gen (.*);

  int total = 0, bad = 0, stall_seed = 7;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble();
    req_write = ~req_write; req_size = req_size + 2'd1; req_bus = ~req_bus;
    req_dev = ~req_dev; req_func = ~req_func; req_offset = ~req_offset;
    req_wdata = ~req_wdata; root_bus = ~root_bus; sec_bus = ~sec_bus;
  endtask

  task automatic run_pkt(bit wr, logic [1:0] sz, logic [11:0] ofs, logic [7:0] bus,
                         logic [7:0] sec, logic [7:0] root, logic [4:0] dv,
                         logic [2:0] fn, logic [31:0] wd);
    logic [31:0] exp [4];
    logic [7:0] cd, be;
    logic [31:0] dat;
    bit t1;
    t1 = bus > sec;
    cd = wr ? (t1 ? 8'h45 : 8'h44) : (t1 ? 8'h05 : 8'h04);
    case (sz)
      2'd0: begin be = 8'((1 << ofs[1:0]) & 255); dat = 32'((64'(wd & 32'hFF)) << (8 * ofs[1:0])); end
      2'd1: begin be = 8'((3 << ofs[1:0]) & 255); dat = 32'((64'(wd & 32'hFFFF)) << (8 * ofs[1:0])); end
      default: begin be = 8'h0F; dat = wd; end
    endcase
    exp[0] = {cd, 24'd1};
    exp[1] = {root, 8'h00, wr ? 8'h10 : 8'h1D, be};
    exp[2] = 32'(bus) * 32'h0100_0000 + 32'(dv) * 32'h8_0000 + 32'(fn) * 32'h1_0000 + 32'(ofs & 12'hFFC);
    exp[3] = wr ? dat : 32'h0;

    @(negedge clk);
    req_write = wr; req_size = sz; req_offset = ofs; req_bus = bus; sec_bus = sec;
    root_bus = root; req_dev = dv; req_func = fn; req_wdata = wd; req_valid = 1;
    chk("R2 ready before request", req_ready, 1);
    @(negedge clk);
    scramble();                                   // R11 request inputs change mid-packet
    chk("R3 first beat valid", tx_valid, 1);
    for (int b = 0; b < 4; b++) begin
      stall_seed = (stall_seed * 13 + 5) % 101;
      for (int s = 0; s < stall_seed % 3; s++) begin
        tx_ready = 0; req_valid = 1;
        chk("R2 ready low in flight", req_ready, 0);
        @(negedge clk);
        chk("R4 held beat R11", tx_data, exp[b]);
      end
      tx_ready = 1; req_valid = 0;
      chk(b == 0 ? "R6 header0 R5" : b == 1 ? "R7 header1 R8" : b == 2 ? "R9 header2 R11" : "R10 data R11",
          tx_data, exp[b]);
      chk("R3 sop", tx_sop, b == 0);
      chk("R3 eop", tx_eop, b == 3);
      @(negedge clk);
    end
    tx_ready = 0;
    chk("R2 ready after eop", req_ready, 1);
    chk("R3 idle after eop", tx_valid, 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; tx_ready = 0; req_write = 0; req_size = 0; req_bus = 0;
    req_dev = 0; req_func = 0; req_offset = 0; req_wdata = 0; root_bus = 0; sec_bus = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 tx_valid reset", tx_valid, 0);
    chk("R1 req_ready reset", req_ready, 1);
    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 4; lo++)
          for (int rel = 0; rel < 4; rel++) begin
            logic [7:0] sec, bus;
            sec = 8'(16 + sz * 3 + lo);
            bus = rel == 0 ? sec - 8'd1 : rel == 1 ? sec : rel == 2 ? sec + 8'd1 : 8'hFF;
            run_pkt(w[0], 2'(sz), 12'((w * 97 + sz * 331 + rel * 53) * 4 + lo), bus, sec,
                    8'(sz * 5 + rel), 5'(lo * 7 + rel), 3'(sz + rel), 32'hA1B2_C3D4 ^ 32'(rel * 32'h1111_0101 + lo));
          end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule